// File: doc/BRIEF.md
# Two-wire bus slave address and general-call matcher

This block listens to a two-wire serial bus as a slave. It recognises Start, repeated Start and Stop conditions from the sampled SDA and SCL lines. After each Start it captures the first byte on the bus, which is the address byte. The upper seven bits of that byte are compared with a programmed own address. The whole byte is compared with the all-zero general-call code. Two flags report the outcome: an own-address match and a general-call match. A sticky new-match status bit records that either flag has just been set, and it can raise an interrupt request. The block does not drive acknowledge bits and does not move data bytes.

The bus lines come in raw and pass through a parameterised synchronizer. A frame state machine with three states tracks each transfer. ST_IDLE waits for a Start. ST_ADDR counts and shifts in the address bits. ST_HELD keeps the compare result while the rest of the transfer goes by.

The transitions are as follows. ST_IDLE goes to ST_ADDR on a Start. ST_ADDR goes to ST_HELD on the eighth SCL rising edge. ST_ADDR and ST_HELD go back to ST_ADDR on a repeated Start. Any state goes to ST_IDLE on a Stop. A Stop in ST_IDLE keeps the machine in ST_IDLE. A low module enable forces ST_IDLE and clears every flag.

Top module: `i2c_addr_matcher`

## Requirements
- R1: A Start is SDA going from 1 to 0 while SCL stays 1. It opens the capture of a new address byte.
- R2: Address bits are taken MSB first on SCL rising edges. After the eighth bit, `match` sets when `addr_en` is 1 and byte bits [7:1] equal `own_addr`. Bit 0, the direction bit, plays no part in this compare.
- R3: When `addr_en` is 0, `match` stays 0 even for an address byte that matches.
- R4: After the eighth bit, `gc_match` sets when `gc_en` is 1 and the whole byte is 0x00.
- R5: When `gc_en` is 0, an all-zero address byte leaves `gc_match` at 0.
- R6: Both `match` and `gc_match` clear on any Start, repeated Start or Stop. This includes a Stop that falls inside the address byte, where SDA goes from 0 to 1 while SCL stays 1.
- R7: `new_match` sets in the same cycle in which either flag is newly set. It stays at 1 until `nm_clr` is sampled high. If a set and a clear come in the same cycle, the set wins.
- R8: `irq` is 1 exactly when `new_match`, `irq_en` and `nm_irq_en` are all 1.
- R9: While `enable` is 0, the next clock clears `match`, `gc_match`, `new_match` and the frame state.
- R10: After the address byte, further SCL edges (acknowledge and data bits) do not change either flag until the next Start or Stop.
- R11: A flag, and `new_match`, change on the third rising clock edge after the raw bus change that causes them. Two of these cycles are synchronizer stages and one is the edge-detect register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low clears all state |
| sda_in | input | 1 | Raw SDA line sample |
| scl_in | input | 1 | Raw SCL line sample |
| own_addr | input | 7 | Programmed 7-bit slave address |
| addr_en | input | 1 | Own-address match enable |
| gc_en | input | 1 | General-call match enable |
| irq_en | input | 1 | Global interrupt enable |
| nm_irq_en | input | 1 | New-match interrupt enable |
| nm_clr | input | 1 | Write-one-to-clear strobe for new_match |
| match | output | 1 | Own-address match flag |
| gc_match | output | 1 | General-call match flag |
| new_match | output | 1 | Sticky new-match status |
| irq | output | 1 | Interrupt request |

## Verification
The matcher is driven with several kinds of address byte, each chosen to separate one condition from the others:
- A byte equal to the own address with either direction bit, to show that bit 0 is ignored.
- A byte that differs only in its last address bit, to catch an off-by-one shift.
- An all-zero byte with the general-call enable on and then off.
- A matching byte with the address enable off.

Repeated Starts, a Stop in the middle of the address and trailing data bits show which events clear the flags and which are ignored. The interrupt-enable combinations and an enable drop in the middle of a frame cover the gating and clear paths. A behavioural model checks the three-cycle latency on every clock.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_HELD = 2'd2
    } frame_st_t;

    localparam int unsigned ADDR_BITS_DEF = 7;
    localparam int unsigned SYNC_DEPTH_DEF = 2;

endpackage

// File: rtl/i2cam_sync.sv
module i2cam_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    // Each stage idles at 1: an idle bus keeps both lines high.
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        stage_q[gi] <= '1;
                    end else if (!enable) begin
                        stage_q[gi] <= '1;
                    end else begin
                        stage_q[gi] <= raw_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        stage_q[gi] <= '1;
                    end else if (!enable) begin
                        stage_q[gi] <= '1;
                    end else begin
                        stage_q[gi] <= stage_q[gi-1];
                    end
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/i2cam_bus_events.sv
module i2cam_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sda_s,
    input  logic scl_s,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic sda_bit
);

    logic sda_d;
    logic scl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_d <= 1'b1;
            scl_d <= 1'b1;
        end else if (!enable) begin
            sda_d <= 1'b1;
            scl_d <= 1'b1;
        end else begin
            sda_d <= sda_s;
            scl_d <= scl_s;
        end
    end

    logic scl_held_high;
    assign scl_held_high = scl_s & scl_d;

    // Start: SDA 1 -> 0 while SCL stays high. Stop: SDA 0 -> 1 while SCL stays high.
    assign start_evt = enable & scl_held_high &  sda_d & ~sda_s;
    assign stop_evt  = enable & scl_held_high & ~sda_d &  sda_s;
    assign scl_rise  = enable & scl_s & ~scl_d;
    assign sda_bit   = sda_s;

endmodule

// File: rtl/i2cam_frame_fsm.sv
module i2cam_frame_fsm
    import i2cam_pkg::*;
#(
    parameter int unsigned ADDR_W  = 7,
    parameter int unsigned GC_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              scl_rise,
    input  logic              sda_bit,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              addr_en,
    input  logic              gc_en,
    output logic              match_o,
    output logic              gc_o,
    output logic              hit_o
);

    localparam int unsigned BYTE_W   = ADDR_W + 1;
    localparam int unsigned CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);
    localparam logic [BYTE_W-1:0] GC_VAL  = BYTE_W'(GC_CODE);

    frame_st_t state_q, state_d;

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-2:0] shreg_q;
    logic [BYTE_W-1:0] byte_full;
    logic              take_bit;
    logic              last_bit;
    logic              boundary;
    logic              addr_eq;
    logic              gc_eq;

    assign boundary  = start_evt | stop_evt;
    assign byte_full = {shreg_q, sda_bit};
    assign take_bit  = (state_q == ST_ADDR) && scl_rise && !boundary;
    assign last_bit  = take_bit && (cnt_q == LAST_IDX);
    assign addr_eq   = addr_en && (byte_full[BYTE_W-1:1] == own_addr);
    assign gc_eq     = gc_en && (byte_full == GC_VAL);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (!enable) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_evt) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (stop_evt)       state_d = ST_IDLE;
                else if (start_evt) state_d = ST_ADDR;
                else if (last_bit)  state_d = ST_HELD;
            end
            ST_HELD: begin
                if (stop_evt)       state_d = ST_IDLE;
                else if (start_evt) state_d = ST_ADDR;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            match_o <= 1'b0;
            gc_o    <= 1'b0;
        end else if (!enable) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            match_o <= 1'b0;
            gc_o    <= 1'b0;
        end else if (boundary) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            match_o <= 1'b0;
            gc_o    <= 1'b0;
        end else if (take_bit) begin
            shreg_q <= byte_full[BYTE_W-2:0];
            cnt_q   <= cnt_q + 1'b1;
            if (last_bit) begin
                match_o <= addr_eq;
                gc_o    <= gc_eq;
            end
        end
    end

    assign hit_o = last_bit && (addr_eq || gc_eq);

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
    import i2cam_pkg::*;
#(
    parameter int unsigned ADDR_W     = ADDR_BITS_DEF,
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
    parameter int unsigned GC_CODE    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              addr_en,
    input  logic              gc_en,
    input  logic              irq_en,
    input  logic              nm_irq_en,
    input  logic              nm_clr,
    output logic              match,
    output logic              gc_match,
    output logic              new_match,
    output logic              irq
);

    logic [1:0] line_sync;
    logic       sda_s;
    logic       scl_s;
    logic       start_evt;
    logic       stop_evt;
    logic       scl_rise;
    logic       sda_bit;
    logic       hit;
    logic       nm_q;

    i2cam_sync #(
        .STAGES (SYNC_DEPTH),
        .WIDTH  (2)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .raw_i  ({sda_in, scl_in}),
        .sync_o (line_sync)
    );

    assign sda_s = line_sync[1];
    assign scl_s = line_sync[0];

    i2cam_bus_events events_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .sda_s     (sda_s),
        .scl_s     (scl_s),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .scl_rise  (scl_rise),
        .sda_bit   (sda_bit)
    );

    i2cam_frame_fsm #(
        .ADDR_W  (ADDR_W),
        .GC_CODE (GC_CODE)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .scl_rise  (scl_rise),
        .sda_bit   (sda_bit),
        .own_addr  (own_addr),
        .addr_en   (addr_en),
        .gc_en     (gc_en),
        .match_o   (match),
        .gc_o      (gc_match),
        .hit_o     (hit)
    );

    // Sticky new-match status: a set wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nm_q <= 1'b0;
        end else if (!enable) begin
            nm_q <= 1'b0;
        end else if (hit) begin
            nm_q <= 1'b1;
        end else if (nm_clr) begin
            nm_q <= 1'b0;
        end
    end

    assign new_match = nm_q;
    assign irq       = nm_q & irq_en & nm_irq_en;

endmodule

// File: rtl/i2cam_checker.sv
module i2cam_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic addr_en,
    input logic gc_en,
    input logic irq_en,
    input logic nm_irq_en,
    input logic nm_clr,
    input logic start_evt,
    input logic stop_evt,
    input logic match,
    input logic gc_match,
    input logic new_match,
    input logic irq
);

    // R9
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!match && !gc_match && !new_match));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && nm_irq_en && new_match));

    // R3
    addr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match) |-> $past(addr_en));

    // R4
    gc_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gc_match) |-> $past(gc_en));

    // R6
    boundary_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt || stop_evt) |=> (!match && !gc_match));

    // R7
    nm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(new_match) |-> ($past(nm_clr) || !$past(enable)));

    // R7
    nm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(new_match) |-> (match || gc_match));

endmodule

bind i2c_addr_matcher i2cam_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .addr_en   (addr_en),
    .gc_en     (gc_en),
    .irq_en    (irq_en),
    .nm_irq_en (nm_irq_en),
    .nm_clr    (nm_clr),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .match     (match),
    .gc_match  (gc_match),
    .new_match (new_match),
    .irq       (irq)
);

// File: tb/i2c_addr_matcher_tb_top.sv
module i2c_addr_matcher_tb_top;

    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       sda_in = 1'b1;
    logic       scl_in = 1'b1;
    logic [6:0] own_addr = 7'h00;
    logic       addr_en = 1'b0;
    logic       gc_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       nm_irq_en = 1'b0;
    logic       nm_clr = 1'b0;
    logic       match, gc_match, new_match, irq;

    int errors = 0;
    int checks = 0;
    string cur_req = "R11";

    always #5 clk = ~clk;

    i2c_addr_matcher dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .sda_in(sda_in), .scl_in(scl_in), .own_addr(own_addr),
        .addr_en(addr_en), .gc_en(gc_en), .irq_en(irq_en),
        .nm_irq_en(nm_irq_en), .nm_clr(nm_clr),
        .match(match), .gc_match(gc_match), .new_match(new_match), .irq(irq)
    );

    // Behavioural reference model: raw-line history, then the bus rules.
    bit [2:0] hs, hc;
    bit m_m, m_g, m_nm, in_addr;
    int cnt, acc;

    always @(posedge clk) begin
        if (!rst_n || !enable) begin
            hs = 3'b111; hc = 3'b111;
            m_m = 0; m_g = 0; m_nm = 0; in_addr = 0; cnt = 0; acc = 0;
        end else begin
            bit s_now, s_old, c_now, c_old, st, sp, rise, hit;
            s_now = hs[1]; s_old = hs[2]; c_now = hc[1]; c_old = hc[2];
            st   = c_now && c_old && s_old && !s_now;
            sp   = c_now && c_old && !s_old && s_now;
            rise = c_now && !c_old;
            hit  = 0;
            if (st || sp) begin
                m_m = 0; m_g = 0; cnt = 0; acc = 0; in_addr = st;
            end else if (in_addr && rise) begin
                acc = (acc * 2 + int'(s_now)) & 255;
                cnt++;
                if (cnt == 8) begin
                    in_addr = 0;
                    m_m = addr_en && ((acc / 2) == int'(own_addr));
                    m_g = gc_en && (acc == 0);
                    hit = m_m || m_g;
                end
            end
            if (hit) m_nm = 1;
            else if (nm_clr) m_nm = 0;
            hs = {hs[1:0], sda_in};
            hc = {hc[1:0], scl_in};
        end
    end

    // Per-cycle comparison, away from the clock edge. R11 covers the latency.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            bit e_irq;
            e_irq = m_nm && irq_en && nm_irq_en;
            checks++;
            if (match !== m_m || gc_match !== m_g || new_match !== m_nm || irq !== e_irq) begin
                errors++;
                $display("FAIL %s R11 cycle model: actual m=%0b g=%0b nm=%0b irq=%0b expected m=%0b g=%0b nm=%0b irq=%0b",
                         cur_req, match, gc_match, new_match, irq, m_m, m_g, m_nm, e_irq);
            end
        end
    end

    task automatic expect4(input bit em, input bit eg, input bit enm, input bit eirq, input string tag);
        checks++;
        if (match !== em || gc_match !== eg || new_match !== enm || irq !== eirq) begin
            errors++;
            $display("FAIL %s: actual m=%0b g=%0b nm=%0b irq=%0b expected m=%0b g=%0b nm=%0b irq=%0b",
                     tag, match, gc_match, new_match, irq, em, eg, enm, eirq);
        end
    endtask

    task automatic phase(input bit s, input bit c);
        @(negedge clk);
        sda_in = s; scl_in = c;
        repeat (HOLD - 1) @(negedge clk);
    endtask

    task automatic bus_start();   phase(1, 1); phase(0, 1); phase(0, 0); endtask
    task automatic bus_rstart();  phase(1, 0); phase(1, 1); phase(0, 1); phase(0, 0); endtask
    task automatic bus_stop();    phase(0, 0); phase(0, 1); phase(1, 1); endtask

    task automatic send_bit(input bit b);
        phase(b, 0); phase(b, 1); phase(b, 0);
    endtask

    task automatic send_byte(input bit [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic clear_nm();
        @(negedge clk); nm_clr = 1'b1;
        @(negedge clk); nm_clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; enable = 1'b1;
        repeat (3) @(negedge clk);
        expect4(0, 0, 0, 0, "R9 reset state");

        own_addr = 7'h2D; addr_en = 1'b1;
        cur_req = "R2";
        bus_start();
        send_byte({7'h2D, 1'b0});
        expect4(1, 0, 1, 0, "R1 R2 own address write");
        send_bit(0); send_byte(8'hFF); send_bit(1);
        cur_req = "R10";
        expect4(1, 0, 1, 0, "R10 data bits ignored");
        clear_nm();
        expect4(1, 0, 0, 0, "R7 new_match cleared by nm_clr");
        cur_req = "R6";
        bus_stop();
        expect4(0, 0, 0, 0, "R6 stop clears match");

        cur_req = "R2";
        bus_start();
        send_byte({7'h2D, 1'b1});
        expect4(1, 0, 1, 0, "R2 direction bit ignored");
        bus_rstart();
        expect4(0, 0, 1, 0, "R6 repeated start clears, R7 nm kept");
        send_byte({7'h2C, 1'b1});
        expect4(0, 0, 1, 0, "R2 last address bit differs");
        clear_nm();
        bus_stop();

        cur_req = "R3";
        addr_en = 1'b0;
        bus_start();
        send_byte({7'h2D, 1'b0});
        expect4(0, 0, 0, 0, "R3 addr_en off");
        bus_stop();

        cur_req = "R4";
        gc_en = 1'b1;
        bus_start();
        send_byte(8'h00);
        expect4(0, 1, 1, 0, "R4 general call");
        cur_req = "R8";
        irq_en = 1'b1; @(negedge clk);
        expect4(0, 1, 1, 0, "R8 only global enable");
        nm_irq_en = 1'b1; @(negedge clk);
        expect4(0, 1, 1, 1, "R8 both enables");
        irq_en = 1'b0; @(negedge clk);
        expect4(0, 1, 1, 0, "R8 only new-match enable");
        irq_en = 1'b1;
        clear_nm();
        expect4(0, 1, 0, 0, "R7 R8 cleared irq drops");
        bus_stop();

        cur_req = "R5";
        gc_en = 1'b0;
        bus_start();
        send_byte(8'h00);
        expect4(0, 0, 0, 0, "R5 general call disabled");
        bus_stop();

        cur_req = "R6";
        addr_en = 1'b1;
        bus_start();
        send_bit(0); send_bit(1); send_bit(0);
        phase(0, 0); phase(0, 1); phase(1, 1);
        phase(1, 0);
        send_byte({7'h2D, 1'b0});
        expect4(0, 0, 0, 0, "R6 stop inside address aborts capture");
        bus_start();
        send_bit(0); send_bit(1);
        bus_rstart();
        send_byte({7'h2D, 1'b0});
        expect4(1, 0, 1, 1, "R1 R6 restart mid-address recaptures");

        cur_req = "R9";
        @(negedge clk); enable = 1'b0;
        @(negedge clk); @(negedge clk);
        expect4(0, 0, 0, 0, "R9 enable low clears");
        enable = 1'b1;
        phase(1, 1);
        bus_start();
        send_byte({7'h2D, 1'b0});
        expect4(1, 0, 1, 1, "R9 works after re-enable");
        bus_stop();
        repeat (4) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule